// File: doc/BRIEF.md
# Banked register file decoder

This block is the data-memory side of a small 8-bit processor core. The core presents a 7-bit register offset, a write strobe and write data. The block combines the offset with a bank-select bit held in its own status register and maps the result onto one register file. That file holds general-purpose static RAM, a status register, a pointer register for indirect access, and plain storage stubs for the remaining control registers. The peripherals behind those stubs live elsewhere.

Offset 00h is a window and holds no storage. An access there is carried out at the offset held in the low seven bits of the pointer register, in the bank the status register currently selects. The general-purpose RAM and a set of shared control registers appear at the same offset in both banks. A few control offsets hold a separate register per bank. Offsets past the end of RAM are empty and read as zero.

Top module: `banked_regfile`

## Requirements
- R1: On a clock edge with `rst_n` low, the status register (offset 03h) and the pointer register (offset 04h) become 00h, so bank 0 is selected.
- R2: Bit 5 of the status register selects the bank: 0 for bank 0 and 1 for bank 1. Offsets 01h and 05h–09h hold a separate register in each bank, and these registers clear to 00h on reset.
- R3: Offsets 0Ch–4Fh reach 68 bytes of general-purpose RAM. The same byte is reached from either bank, so overall addresses 0Ch and 8Ch are one location.
- R4: Offsets 50h–7Fh in either bank read as 00h. Writes there change no stored value.
- R5: Offsets 02h, 03h, 04h, 0Ah and 0Bh are each one register seen from both banks. 02h, 0Ah and 0Bh are plain storage that clears to 00h on reset.
- R6: An access at offset 00h is performed at the offset given by pointer bits 6:0, in the bank selected by status bit 5. Pointer bit 7 plays no part.
- R7: When pointer bits 6:0 are zero, a read at offset 00h returns 00h and a write at offset 00h changes nothing.
- R8: A write takes effect on the rising clock edge while `wr_en` is high. `rdata` follows the current offset, bank bit and pointer combinationally, so during a write cycle it shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 7 | Register offset within the selected bank |
| wr_en | input | 1 | Write strobe for the current offset |
| wdata | input | 8 | Data to write |
| rdata | output | 8 | Read data for the current offset |

## Verification
The assertions assume that `addr`, `wr_en` and `wdata` are stable and known at each rising edge once reset is released. They also assume that reset is held for at least one edge before any check that depends on it. The bench changes inputs only on falling edges and holds reset low for several cycles at the start. Its random offsets and data come from a seeded generator and are always defined values. Some operations are deliberately aimed at offset 00h, at the status register and at the pointer register, so that bank changes and indirect access occur often without leaving the valid input space.

// File: rtl/banked_regfile_pkg.sv
// Package: shared widths and the decoded-selection type for the banked
// register file. Assumes 8-bit data and 7-bit in-bank offsets.
package banked_regfile_pkg;

    localparam int OFF_W  = 7;
    localparam int DATA_W = 8;

    // Storage class that one access lands on
    typedef enum logic [2:0] {
        RGN_NONE,     // empty offset or self-pointing window
        RGN_GPR,      // general-purpose RAM
        RGN_STATUS,   // status register (holds the bank bit)
        RGN_PTR,      // indirect pointer register
        RGN_SHARED,   // control stub, one copy for both banks
        RGN_BANKED    // control stub, one copy per bank
    } region_e;

    typedef struct packed {
        region_e              rgn;
        logic [OFF_W-1:0]     idx;   // index within the region
        logic                 bank;  // bank in force for this access
    } sel_t;

endpackage

// File: rtl/banked_regfile_decode.sv
// Module: banked_regfile_decode
// Turns an offset, the live bank bit and the pointer register into a region
// and an index. Offset 0 is replaced by pointer bits 6:0; a pointer that itself
// names offset 0 decodes to RGN_NONE. Purely combinational.
// Assumes GPR_BASE + GPR_DEPTH <= 2**OFF_W.
module banked_regfile_decode
    import banked_regfile_pkg::*;
#(
    parameter int GPR_BASE  = 12,
    parameter int GPR_DEPTH = 68
) (
    input  logic [OFF_W-1:0]  addr,
    input  logic              bank,
    input  logic [DATA_W-1:0] ptr,
    output sel_t              sel
);

    localparam logic [OFF_W-1:0] BASE_L = OFF_W'(GPR_BASE);
    localparam logic [OFF_W-1:0] END_L  = OFF_W'(GPR_BASE + GPR_DEPTH);

    logic [OFF_W-1:0] off;
    wire unused_ptr_hi = ptr[DATA_W-1];

    // Pick the effective offset: direct, or through the pointer at offset 0
    always_comb begin
        off = (addr == '0) ? ptr[OFF_W-1:0] : addr;
    end

    // Classify the effective offset into a region and a local index
    always_comb begin
        sel.bank = bank;
        sel.rgn  = RGN_NONE;
        sel.idx  = '0;
        if (off >= BASE_L && off < END_L) begin
            sel.rgn = RGN_GPR;
            sel.idx = off - BASE_L;
        end else begin
            case (off)
                7'h01: begin sel.rgn = RGN_BANKED; sel.idx = 7'd0; end
                7'h02: begin sel.rgn = RGN_SHARED; sel.idx = 7'd0; end
                7'h03: sel.rgn = RGN_STATUS;
                7'h04: sel.rgn = RGN_PTR;
                7'h05, 7'h06, 7'h07, 7'h08, 7'h09: begin
                    sel.rgn = RGN_BANKED;
                    sel.idx = off - 7'd4;
                end
                7'h0A: begin sel.rgn = RGN_SHARED; sel.idx = 7'd1; end
                7'h0B: begin sel.rgn = RGN_SHARED; sel.idx = 7'd2; end
                default: sel.rgn = RGN_NONE;
            endcase
        end
    end

endmodule

// File: rtl/banked_regfile_gpr.sv
// Module: banked_regfile_gpr
// General-purpose RAM: one array shared by both banks, written on the clock
// edge, read combinationally. Contents are not reset.
// Assumes idx is below DEPTH whenever we is high.
module banked_regfile_gpr
    import banked_regfile_pkg::*;
#(
    parameter int DEPTH = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFF_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte on the write edge
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Combinational read of the addressed byte
    assign rd = mem[idx];

    AST_GPR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wdata))); // R3

endmodule

// File: rtl/banked_regfile_ctrl.sv
// Module: banked_regfile_ctrl
// Status and pointer registers plus stub storage for the other control
// registers: shared stubs have one copy, banked stubs one copy per bank.
// Synchronous active-low reset clears everything held here.
module banked_regfile_ctrl
    import banked_regfile_pkg::*;
#(
    parameter int N_SHARED = 3,
    parameter int N_BANKED = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  sel_t              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] ptr_q,
    output logic [DATA_W-1:0] rd
);

    localparam int NUM_BANKS = 2;
    localparam int SH_W      = (N_SHARED > 1) ? $clog2(N_SHARED) : 1;
    localparam int SLOT_W    = (N_BANKED > 1) ? $clog2(N_BANKED) : 1;

    logic [DATA_W-1:0] sh_q [N_SHARED];
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
    logic [SH_W-1:0]   sh_i;
    logic [SLOT_W-1:0] slot;

    assign sh_i = sel.idx[SH_W-1:0];
    assign slot = sel.idx[SLOT_W-1:0];
    wire unused_idx_hi = ^sel.idx[OFF_W-1:SH_W];

    // Status register: reset clears the bank bit with the rest
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else if (we && sel.rgn == RGN_STATUS) status_q <= wdata;
    end

    // Pointer register for the indirect window
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (we && sel.rgn == RGN_PTR) ptr_q <= wdata;
    end

    // Shared stubs: one copy reached from both banks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SHARED; i++) sh_q[i] <= '0;
        end else if (we && sel.rgn == RGN_SHARED) begin
            sh_q[sh_i] <= wdata;
        end
    end

    // Banked stubs: one storage set per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] q [N_BANKED];

        // Write only the copy that belongs to the bank in force
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < N_BANKED; i++) q[i] <= '0;
            end else if (we && sel.rgn == RGN_BANKED && sel.bank == 1'(b)) begin
                q[slot] <= wdata;
            end
        end

        assign bank_rd[b] = q[slot];
    end

    // Read mux over the control registers
    always_comb begin
        case (sel.rgn)
            RGN_STATUS: rd = status_q;
            RGN_PTR:    rd = ptr_q;
            RGN_SHARED: rd = sh_q[sh_i];
            RGN_BANKED: rd = bank_rd[sel.bank];
            default:    rd = '0;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && ptr_q == '0)); // R1

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel.rgn == RGN_PTR) |=> (ptr_q == $past(wdata))); // R6

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel.rgn == RGN_STATUS) |=> $stable(status_q)); // R2

endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// Data-memory port of a small 8-bit core: decodes offset + bank bit (or the
// indirect window) and routes reads and writes to RAM or control storage.
// Assumes inputs are stable around each rising edge; reset is synchronous.
module banked_regfile
    import banked_regfile_pkg::*;
#(
    parameter int GPR_BASE  = 12,
    parameter int GPR_DEPTH = 68,
    parameter int BANK_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    sel_t              sel;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] gpr_rd;
    logic [DATA_W-1:0] ctrl_rd;
    logic              gpr_we;

    banked_regfile_decode #(
        .GPR_BASE  (GPR_BASE),
        .GPR_DEPTH (GPR_DEPTH)
    ) u_decode (
        .addr (addr),
        .bank (status_q[BANK_BIT]),
        .ptr  (ptr_q),
        .sel  (sel)
    );

    assign gpr_we = wr_en && (sel.rgn == RGN_GPR);

    banked_regfile_gpr #(
        .DEPTH (GPR_DEPTH)
    ) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .idx   (sel.idx),
        .wdata (wdata),
        .rd    (gpr_rd)
    );

    banked_regfile_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .sel      (sel),
        .wdata    (wdata),
        .status_q (status_q),
        .ptr_q    (ptr_q),
        .rd       (ctrl_rd)
    );

    // Final read mux: RAM, control storage, or zero for empty space
    always_comb begin
        case (sel.rgn)
            RGN_GPR:  rdata = gpr_rd;
            RGN_NONE: rdata = '0;
            default:  rdata = ctrl_rd;
        endcase
    end

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != '0 && addr >= OFF_W'(GPR_BASE + GPR_DEPTH)) |-> (rdata == '0)); // R4

    AST_SELF_PTR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0 && ptr_q[OFF_W-1:0] == '0) |-> (rdata == '0)); // R7

    AST_SELF_PTR_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && ptr_q[OFF_W-1:0] == '0)
        |=> ($stable(status_q) && $stable(ptr_q))); // R7

endmodule

// File: tb/banked_regfile_bench.sv
// Bench: seeded random traffic plus directed corner cases, each read checked
// against a reference model held in bench functions.
module banked_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int total = 0;
    int fails = 0;

    // Reference state
    logic [7:0] m_gpr [68];
    logic [7:0] m_bank [2][6];
    logic [7:0] m_sh [3];
    logic [7:0] m_status;
    logic [7:0] m_ptr;

    banked_regfile u_banked_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Effective offset per R6/R7; -1 marks the self-pointing window
    function automatic int eff_off(input logic [6:0] a);
        if (a != 0) return int'(a);
        if (m_ptr[6:0] == 0) return -1;
        return int'(m_ptr[6:0]);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [6:0] a);
        int o = eff_off(a);
        int b = int'(m_status[5]);
        if (o < 0) return 8'h00;
        if (o >= 12 && o < 80) return m_gpr[o-12];
        case (o)
            1: return m_bank[b][0];
            2: return m_sh[0];
            3: return m_status;
            4: return m_ptr;
            5, 6, 7, 8, 9: return m_bank[b][o-4];
            10: return m_sh[1];
            11: return m_sh[2];
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [6:0] a, input logic [7:0] d);
        int o = eff_off(a);
        int b = int'(m_status[5]);
        if (o < 0) return;
        if (o >= 12 && o < 80) begin m_gpr[o-12] = d; return; end
        case (o)
            1: m_bank[b][0] = d;
            2: m_sh[0] = d;
            3: m_status = d;
            4: m_ptr = d;
            5, 6, 7, 8, 9: m_bank[b][o-4] = d;
            10: m_sh[1] = d;
            11: m_sh[2] = d;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [6:0] a);
        int o = eff_off(a);
        if (a == 0) return (o < 0) ? "R7" : "R6";
        if (o >= 12 && o < 80) return "R3";
        if (o >= 80) return "R4";
        if (o == 2 || o == 3 || o == 4 || o == 10 || o == 11) return "R5";
        return "R2";
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h (addr=%02h status=%02h ptr=%02h)",
                     req, act, exp, addr, m_status, m_ptr);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wdata = d;
        @(posedge clk);
        #1;
        m_write(a, d);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] a, input string req);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1;
        check(rdata, exp_rd(a), req);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] old;
        void'($urandom(32'h5EED_1234));
        m_status = 8'h00; m_ptr = 8'h00;
        for (int i = 0; i < 3; i++) m_sh[i] = 8'h00;
        for (int b = 0; b < 2; b++) for (int i = 0; i < 6; i++) m_bank[b][i] = 8'h00;
        for (int i = 0; i < 68; i++) m_gpr[i] = 8'hxx;

        // Put junk in the registers, then reset
        @(negedge clk); rst_n = 1'b1; addr = 7'h03; wr_en = 1'b1; wdata = 8'hFF;
        @(negedge clk); addr = 7'h04; wdata = 8'h99;
        @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        do_read(7'h03, "R1");
        do_read(7'h04, "R1");
        do_read(7'h01, "R1");

        // Fill RAM from bank 0
        for (int i = 0; i < 68; i++) do_write(7'(12 + i), 8'(i * 7 + 3));

        // R3: write 0Ch in bank 0, read 8Ch through bank 1
        do_write(7'h0C, 8'hA5);
        do_write(7'h03, 8'h20);
        do_read(7'h0C, "R3");
        // R3: write 8Dh in bank 1, read 0Dh through bank 0
        do_write(7'h0D, 8'h5A);
        do_write(7'h03, 8'h00);
        do_read(7'h0D, "R3");
        do_read(7'h4F, "R3");

        // R4: empty space reads zero, writes go nowhere
        do_write(7'h50, 8'hFF);
        do_read(7'h50, "R4");
        do_write(7'h03, 8'h20);
        do_write(7'h7F, 8'hEE);
        do_read(7'h7F, "R4");
        do_read(7'h4F, "R4");

        // R2: per-bank copies at 01h and 09h
        do_write(7'h01, 8'h22);
        do_write(7'h09, 8'h44);
        do_write(7'h03, 8'h00);
        do_write(7'h01, 8'h11);
        do_read(7'h01, "R2");
        do_read(7'h09, "R2");
        do_write(7'h03, 8'h20);
        do_read(7'h01, "R2");
        do_read(7'h09, "R2");

        // R5: shared register written in bank 1, read in bank 0
        do_write(7'h0A, 8'hC3);
        do_write(7'h03, 8'h00);
        do_read(7'h0A, "R5");

        // R6: indirect write and read, then a bank change under the same pointer
        do_write(7'h04, 8'h10);
        do_write(7'h00, 8'h77);
        do_read(7'h10, "R6");
        do_write(7'h03, 8'h20);
        do_read(7'h00, "R6");
        do_write(7'h04, 8'h01);   // bit 7 clear, bank bit picks bank 1
        do_read(7'h00, "R6");
        do_write(7'h04, 8'h81);   // bit 7 set, still bank 1
        do_read(7'h00, "R6");

        // R7: self-pointing window
        do_write(7'h04, 8'h80);
        do_read(7'h00, "R7");
        do_write(7'h00, 8'h33);
        do_read(7'h04, "R7");
        do_read(7'h03, "R7");

        // R8: during the write cycle rdata still shows the old value
        do_write(7'h03, 8'h00);
        @(negedge clk);
        old = exp_rd(7'h20);
        addr = 7'h20; wr_en = 1'b1; wdata = 8'h3C;
        #1 check(rdata, old, "R8");
        @(posedge clk);
        #1;
        m_write(7'h20, 8'h3C);
        #1 check(rdata, 8'h3C, "R8");
        wr_en = 1'b0;

        // Random traffic, biased toward the window, status and pointer
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [6:0] a;
            logic [7:0] d;
            int pick = int'($urandom % 8);
            case (pick)
                0: a = 7'h00;
                1: a = 7'h03;
                2: a = 7'h04;
                default: a = 7'($urandom);
            endcase
            d = 8'($urandom);
            if (($urandom % 3) == 0) do_write(a, d);
            else do_read(a, tag_of(a));
        end

        finish_run();
    end

endmodule